// File: doc/BRIEF.md
# Back-to-back MII link emulator

This block stands in for a pair of physical-layer devices, so that two MAC instances can be wired port to port and trade frames in simulation. Each of the two 4-bit media-independent interface ports, called side A and side B, drives its transmit enable and nibble data into an asynchronous FIFO. That FIFO hands the nibbles to the opposite side's receive port, in the opposite side's receive clock domain. The FIFO depth is a parameter. A depth that is too small, or transmit and receive clocks that drift apart, shows up as dropped nibbles or gaps in receive data-valid. Neither case is smoothed over, so the MACs at each end see the damage.

For each side, the block also produces carrier sense and collision. Carrier sense follows the OR of that side's transmit enable and receive data-valid. Collision follows their AND. Both signals are re-timed onto a fast reference clock. Each rising edge of either signal is held back by a pseudo-random number of reference cycles, drawn from a seeded LFSR and shorter than one nibble period. Each receive port carries a receive-error flag. The flag fires at a low, parameter-set pseudo-random rate, and only alongside valid data. The transmit-error inputs have no effect on anything.

Top module: `mii_loopback_link`

## Requirements
- R1: While rst_n is low, and afterwards while both transmit enables stay low, every rx_dv, rx_er, crs and col output is 0 and every rxd output is 4'h0.
- R2: Nibbles that side A presents with a_tx_en high appear on b_rxd with b_rx_dv high, in the same order, none lost or repeated, when a_tx_clk and b_rx_clk run at the same rate.
- R3: Side B's transmit stream reaches a_rxd and a_rx_dv under the same conditions as R2.
- R4: The condition is (tx_en OR rx_dv) for that side. Counting the first ref_clk rising edge that samples the condition high as edge 1, crs rises after edge 4+d, where d is a pseudo-random value in 0..NIBBLE_REF_CYCLES-1.
- R5: Once the condition clears, crs falls no later than the second ref_clk rising edge that samples it low. A delayed rise still pending at that point is cancelled.
- R6: col rises, with the same delay window as R4, while that side's tx_en and rx_dv are both high, and stays low while only one of them is high.
- R7: The delay d of R4 is drawn anew for each rise, from an LFSR seeded by SEED_A or SEED_B. Across several frames, more than one delay value appears.
- R8: rx_er is high only in cycles where the same side's rx_dv is high. In each such cycle it fires when an 8-bit LFSR draw is below RXERR_THRESH, a rate of RXERR_THRESH/256. rxd still carries the transmitted nibble in that cycle.
- R9: a_tx_er and b_tx_er are ignored: a frame sent with tx_er held high is received unchanged, with the same error behaviour.
- R10: When a FIFO is full, further nibbles written into it are dropped and stored ones are never overwritten. The received stream is then shorter than the sent one but is an in-order subsequence of it.
- R11: When a FIFO runs empty in the middle of a frame because the receive clock is faster, rx_dv deasserts until more nibbles arrive. No nibble is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Fast reference clock that times the carrier and collision delays |
| rst_n | input | 1 | Asynchronous active-low reset for all domains |
| a_tx_clk | input | 1 | Side A transmit nibble clock |
| a_tx_en | input | 1 | Side A transmit enable |
| a_txd | input | 4 | Side A transmit nibble |
| a_tx_er | input | 1 | Side A transmit error (ignored) |
| a_rx_clk | input | 1 | Side A receive nibble clock |
| a_rx_dv | output | 1 | Side A receive data valid |
| a_rxd | output | 4 | Side A receive nibble |
| a_rx_er | output | 1 | Side A injected receive error |
| a_crs | output | 1 | Side A carrier sense |
| a_col | output | 1 | Side A collision |
| b_tx_clk | input | 1 | Side B transmit nibble clock |
| b_tx_en | input | 1 | Side B transmit enable |
| b_txd | input | 4 | Side B transmit nibble |
| b_tx_er | input | 1 | Side B transmit error (ignored) |
| b_rx_clk | input | 1 | Side B receive nibble clock |
| b_rx_dv | output | 1 | Side B receive data valid |
| b_rxd | output | 4 | Side B receive nibble |
| b_rx_er | output | 1 | Side B injected receive error |
| b_crs | output | 1 | Side B carrier sense |
| b_col | output | 1 | Side B collision |

## Verification
The embedded checks assume three things about the inputs: every clock runs freely once reset is released, tx_en and txd change only away from the rising edge of their own transmit clock, and the two-flop synchronizers settle within one reference cycle. The delay-window check relies on the condition staying high long enough to finish its countdown, or else on the condition clearing, which restarts the count. The stimulus changes transmit inputs only on falling transmit-clock edges. It keeps the nominal nibble clocks on a grid that never coincides with a rising edge of ref_clk. It alters clock rates only between frames, to provoke overflow and underrun on purpose.

// File: rtl/mii_link_pkg.sv
package mii_link_pkg;

   localparam int LFSR_W = 16;

   // Maximal-length 16-bit Fibonacci LFSR step (taps 16,14,13,11)
   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
   endfunction

   // Byte-swap a seed so that derived seeds stay non-zero
   function automatic logic [LFSR_W-1:0] seed_swap(input logic [LFSR_W-1:0] s);
      return {s[7:0], s[15:8]};
   endfunction

endpackage

// File: rtl/mii_cdc_fifo.sv
module mii_cdc_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 4
) (
   input  logic              rst_n,
   input  logic              wr_clk,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_clk,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);

   initial begin
      assert (DEPTH >= 4 && (1 << AW) == DEPTH)
         else $error("mii_cdc_fifo: DEPTH must be a power of two, at least 4");
   end

   function automatic logic [AW:0] b2g(input logic [AW:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [AW:0] g2b(input logic [AW:0] g);
      logic [AW:0] b;
      b[AW] = g[AW];
      for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction

   logic [DATA_W-1:0] mem [DEPTH];
   logic [AW:0] wbin, wgray, rq1, rq2;
   logic [AW:0] rbin, rgray, wq1, wq2;
   logic        full, push, empty;

   // ---------------- write domain ----------------
   assign full = (wgray == {~rq2[AW:AW-1], rq2[AW-2:0]});
   assign push = wr_en & ~full;   // overflow: nibble dropped

   always_ff @(posedge wr_clk) begin
      if (push) mem[wbin[AW-1:0]] <= wr_data;
   end

   always_ff @(posedge wr_clk or negedge rst_n) begin
      if (!rst_n) begin
         wbin  <= '0;
         wgray <= '0;
         rq1   <= '0;
         rq2   <= '0;
      end else begin
         rq1 <= rgray;
         rq2 <= rq1;
         if (push) begin
            wbin  <= wbin + 1'b1;
            wgray <= b2g(wbin + 1'b1);
         end
      end
   end

   // R10: stored entries never exceed the depth, so nothing is overwritten
   assert_no_overflow_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
      (wbin - g2b(rq2)) <= DEPTH_V);
   // R10: the pointer crossing the domain moves by at most one Gray bit
   assert_gray_step_R10: assert property (@(posedge wr_clk) disable iff (!rst_n)
      $onehot0(wgray ^ $past(wgray)));

   // ---------------- read domain ----------------
   assign empty = (rgray == wq2);

   always_ff @(posedge rd_clk or negedge rst_n) begin
      if (!rst_n) begin
         rbin     <= '0;
         rgray    <= '0;
         wq1      <= '0;
         wq2      <= '0;
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         wq1 <= wgray;
         wq2 <= wq1;
         if (!empty) begin
            rbin     <= rbin + 1'b1;
            rgray    <= b2g(rbin + 1'b1);
            rd_valid <= 1'b1;
            rd_data  <= mem[rbin[AW-1:0]];
         end else begin
            rd_valid <= 1'b0;   // underrun: valid drops
            rd_data  <= '0;
         end
      end
   end

   // R11: the reader never passes the synchronized writer
   assert_read_bound_R11: assert property (@(posedge rd_clk) disable iff (!rst_n)
      (g2b(wq2) - rbin) <= DEPTH_V);

endmodule

// File: rtl/mii_rx_err_stage.sv
module mii_rx_err_stage #(
   parameter logic [15:0] SEED   = 16'h1D2B,
   parameter int          THRESH = 4
) (
   input  logic       rst_n,
   input  logic       clk,
   input  logic       valid_i,
   input  logic [3:0] data_i,
   output logic       rx_dv_o,
   output logic [3:0] rxd_o,
   output logic       rx_er_o
);
   import mii_link_pkg::*;

   localparam logic [8:0] THR9 = 9'(THRESH);

   initial begin
      assert (SEED != 16'h0 && THRESH >= 0 && THRESH <= 256)
         else $error("mii_rx_err_stage: SEED must be non-zero, THRESH in 0..256");
   end

   logic [LFSR_W-1:0] lfsr;
   logic              hit;

   assign hit = ({1'b0, lfsr[7:0]} < THR9);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lfsr    <= SEED;
         rx_dv_o <= 1'b0;
         rxd_o   <= 4'h0;
         rx_er_o <= 1'b0;
      end else begin
         lfsr    <= lfsr_step(lfsr);
         rx_dv_o <= valid_i;
         rxd_o   <= data_i;
         rx_er_o <= valid_i & hit;
      end
   end

   // R8: the error draw never locks up at zero
   assert_lfsr_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

endmodule

// File: rtl/mii_carrier_gen.sv
module mii_carrier_gen #(
   parameter int          NIBBLE_REF_CYCLES = 4,
   parameter logic [15:0] SEED              = 16'hACE1
) (
   input  logic rst_n,
   input  logic ref_clk,
   input  logic tx_en,
   input  logic rx_dv,
   output logic crs,
   output logic col
);
   import mii_link_pkg::*;

   localparam logic [7:0] N8   = 8'(NIBBLE_REF_CYCLES);
   localparam logic [8:0] WMAX = 9'(NIBBLE_REF_CYCLES + 1);

   initial begin
      assert (NIBBLE_REF_CYCLES >= 2 && NIBBLE_REF_CYCLES <= 255 && SEED != 16'h0)
         else $error("mii_carrier_gen: bad NIBBLE_REF_CYCLES or zero SEED");
   end

   logic [1:0]        tx_sync, rx_sync;
   logic [1:0]        cond, out;
   logic [LFSR_W-1:0] lfsr;

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sync <= '0;
         rx_sync <= '0;
         lfsr    <= SEED;
      end else begin
         tx_sync <= {tx_sync[0], tx_en};
         rx_sync <= {rx_sync[0], rx_dv};
         lfsr    <= lfsr_step(lfsr);
      end
   end

   assign cond[0] = tx_sync[1] | rx_sync[1];   // carrier
   assign cond[1] = tx_sync[1] & rx_sync[1];   // collision

   for (genvar k = 0; k < 2; k++) begin : g_chan
      logic [7:0] cnt;
      logic [7:0] draw;
      logic       pend, done;
      logic [8:0] wcnt;

      assign draw = lfsr[8*k +: 8] % N8;

      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt  <= '0;
            pend <= 1'b0;
            done <= 1'b0;
         end else if (!cond[k]) begin
            cnt  <= '0;          // cancels a pending rise
            pend <= 1'b0;
            done <= 1'b0;
         end else if (!pend && !done) begin
            pend <= 1'b1;
            cnt  <= draw;
         end else if (pend) begin
            if (cnt == 8'd0) begin
               pend <= 1'b0;
               done <= 1'b1;
            end else begin
               cnt <= cnt - 8'd1;
            end
         end
      end

      assign out[k] = cond[k] & done;

      // waiting-time monitor for the delay window
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n)                       wcnt <= '0;
         else if (cond[k] && !out[k]) begin
            if (wcnt != '1)                wcnt <= wcnt + 9'd1;
         end else                          wcnt <= '0;
      end

      // R4/R6: a held condition is reflected within one nibble period
      assert_delay_window_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
         wcnt <= WMAX);
   end

   // R7: the delay source never locks up at zero
   assert_delay_lfsr_live_R7: assert property (@(posedge ref_clk) disable iff (!rst_n)
      lfsr != '0);

   assign crs = out[0];
   assign col = out[1];

endmodule

// File: rtl/mii_loopback_link.sv
module mii_loopback_link #(
   parameter int          FIFO_DEPTH        = 16,
   parameter int          NIBBLE_REF_CYCLES = 4,
   parameter logic [15:0] SEED_A            = 16'hACE1,
   parameter logic [15:0] SEED_B            = 16'h5EED,
   parameter int          RXERR_THRESH      = 4
) (
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic       a_tx_clk,
   input  logic       a_tx_en,
   input  logic [3:0] a_txd,
   input  logic       a_tx_er,
   input  logic       a_rx_clk,
   output logic       a_rx_dv,
   output logic [3:0] a_rxd,
   output logic       a_rx_er,
   output logic       a_crs,
   output logic       a_col,
   input  logic       b_tx_clk,
   input  logic       b_tx_en,
   input  logic [3:0] b_txd,
   input  logic       b_tx_er,
   input  logic       b_rx_clk,
   output logic       b_rx_dv,
   output logic [3:0] b_rxd,
   output logic       b_rx_er,
   output logic       b_crs,
   output logic       b_col
);
   import mii_link_pkg::*;

   initial begin
      assert (SEED_A != 16'h0 && SEED_B != 16'h0)
         else $error("mii_loopback_link: seeds must be non-zero");
   end

   // index 0 = side A, index 1 = side B
   logic [1:0]      tx_clk_v, tx_en_v, rx_clk_v;
   logic [1:0][3:0] txd_v;
   logic [1:0]      ff_valid, rx_dv_v, rx_er_v, crs_v, col_v;
   logic [1:0][3:0] ff_data, rxd_v;
   logic            unused_tx_er;

   assign tx_clk_v = {b_tx_clk, a_tx_clk};
   assign tx_en_v  = {b_tx_en,  a_tx_en};
   assign txd_v    = {b_txd,    a_txd};
   assign rx_clk_v = {b_rx_clk, a_rx_clk};
   assign unused_tx_er = a_tx_er ^ b_tx_er;   // transmit error has no effect

   for (genvar d = 0; d < 2; d++) begin : g_dir
      mii_cdc_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(4)) u_fifo (
         .rst_n    (rst_n),
         .wr_clk   (tx_clk_v[d]),
         .wr_en    (tx_en_v[d]),
         .wr_data  (txd_v[d]),
         .rd_clk   (rx_clk_v[1-d]),
         .rd_valid (ff_valid[1-d]),
         .rd_data  (ff_data[1-d])
      );
   end

   for (genvar s = 0; s < 2; s++) begin : g_side
      localparam logic [15:0] SIDE_SEED = (s == 0) ? SEED_A : SEED_B;

      mii_rx_err_stage #(.SEED(seed_swap(SIDE_SEED)), .THRESH(RXERR_THRESH)) u_rxerr (
         .rst_n   (rst_n),
         .clk     (rx_clk_v[s]),
         .valid_i (ff_valid[s]),
         .data_i  (ff_data[s]),
         .rx_dv_o (rx_dv_v[s]),
         .rxd_o   (rxd_v[s]),
         .rx_er_o (rx_er_v[s])
      );

      mii_carrier_gen #(.NIBBLE_REF_CYCLES(NIBBLE_REF_CYCLES), .SEED(SIDE_SEED)) u_carrier (
         .rst_n   (rst_n),
         .ref_clk (ref_clk),
         .tx_en   (tx_en_v[s]),
         .rx_dv   (rx_dv_v[s]),
         .crs     (crs_v[s]),
         .col     (col_v[s])
      );
   end

   assign a_rx_dv = rx_dv_v[0];
   assign a_rxd   = rxd_v[0];
   assign a_rx_er = rx_er_v[0];
   assign a_crs   = crs_v[0];
   assign a_col   = col_v[0];
   assign b_rx_dv = rx_dv_v[1];
   assign b_rxd   = rxd_v[1];
   assign b_rx_er = rx_er_v[1];
   assign b_crs   = crs_v[1];
   assign b_col   = col_v[1];

endmodule

// File: tb/mii_loopback_link_bench.sv
`timescale 1ns/1ps
module mii_loopback_link_bench;

   localparam int DEPTH  = 16;
   localparam int NREF   = 4;
   localparam int THRESH = 4;

   logic ref_clk = 1'b0, rst_n = 1'b0;
   logic a_tx_clk = 1'b0, a_rx_clk = 1'b0, b_tx_clk = 1'b0, b_rx_clk = 1'b0;
   logic a_tx_en = 1'b0, a_tx_er = 1'b0, b_tx_en = 1'b0, b_tx_er = 1'b0;
   logic [3:0] a_txd = 4'h0, b_txd = 4'h0;
   logic a_rx_dv, a_rx_er, a_crs, a_col, b_rx_dv, b_rx_er, b_crs, b_col;
   logic [3:0] a_rxd, b_rxd;

   real a_tx_half = 40.0, a_rx_half = 40.0, b_tx_half = 40.0, b_rx_half = 40.0;

   always #10 ref_clk = ~ref_clk;              // 50 MHz
   always #(a_tx_half) a_tx_clk = ~a_tx_clk;
   always #(a_rx_half) a_rx_clk = ~a_rx_clk;
   always #(b_tx_half) b_tx_clk = ~b_tx_clk;
   always #(b_rx_half) b_rx_clk = ~b_rx_clk;

   mii_loopback_link #(.FIFO_DEPTH(DEPTH), .NIBBLE_REF_CYCLES(NREF),
                       .RXERR_THRESH(THRESH)) u_mii_loopback_link (
      .ref_clk, .rst_n,
      .a_tx_clk, .a_tx_en, .a_txd, .a_tx_er, .a_rx_clk, .a_rx_dv, .a_rxd, .a_rx_er,
      .a_crs, .a_col,
      .b_tx_clk, .b_tx_en, .b_txd, .b_tx_er, .b_rx_clk, .b_rx_dv, .b_rxd, .b_rx_er,
      .b_crs, .b_col
   );

   int checks = 0, fails = 0;
   logic [3:0] a_frm [128], b_frm [128];
   logic [3:0] a_buf [256], b_buf [256];
   int a_n = 0, b_n = 0, b_rises = 0;
   int nib_cnt = 0, er_cnt = 0, er_viol = 0;
   logic a_dv_q = 1'b0, b_dv_q = 1'b0;
   logic col_a_seen = 1'b0, col_b_seen = 1'b0;
   int delays [16];
   int n_delays = 0;

   task automatic report;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- monitors ----------------
   always @(negedge b_rx_clk) if (rst_n) begin
      if (b_rx_dv) begin
         if (b_n < 256) b_buf[b_n] = b_rxd;
         b_n++;
         nib_cnt++;
      end
      if (b_rx_dv && !b_dv_q) b_rises++;
      if (b_rx_er) er_cnt++;
      if (b_rx_er && !b_rx_dv) er_viol++;
      b_dv_q = b_rx_dv;
   end

   always @(negedge a_rx_clk) if (rst_n) begin
      if (a_rx_dv) begin
         if (a_n < 256) a_buf[a_n] = a_rxd;
         a_n++;
         nib_cnt++;
      end
      if (a_rx_er) er_cnt++;
      if (a_rx_er && !a_rx_dv) er_viol++;
      a_dv_q = a_rx_dv;
   end

   always @(negedge ref_clk) begin
      if (a_col) col_a_seen = 1'b1;
      if (b_col) col_b_seen = 1'b1;
   end

   // ---------------- expected-value functions ----------------
   function automatic int b_mismatches(input int n);
      int m = 0;
      for (int i = 0; i < n; i++) if (b_buf[i] !== a_frm[i]) m++;
      return m;
   endfunction

   function automatic int a_mismatches(input int n);
      int m = 0;
      for (int i = 0; i < n; i++) if (a_buf[i] !== b_frm[i]) m++;
      return m;
   endfunction

   function automatic bit b_is_subseq(input int n_sent);
      int j = 0;
      for (int i = 0; i < b_n && i < 256; i++) begin
         while (j < n_sent && a_frm[j] !== b_buf[i]) j++;
         if (j >= n_sent) return 1'b0;
         j++;
      end
      return 1'b1;
   endfunction

   // ---------------- stimulus tasks ----------------
   task automatic fill_frames(input int n);
      for (int i = 0; i < n; i++) begin
         a_frm[i] = 4'($urandom);
         b_frm[i] = 4'($urandom);
      end
   endtask

   task automatic send_a(input int n, input logic er);
      for (int i = 0; i < n; i++) begin
         @(negedge a_tx_clk);
         a_tx_en = 1'b1; a_txd = a_frm[i]; a_tx_er = er;
      end
      @(negedge a_tx_clk);
      a_tx_en = 1'b0; a_txd = 4'h0; a_tx_er = 1'b0;
   endtask

   task automatic send_b(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge b_tx_clk);
         b_tx_en = 1'b1; b_txd = b_frm[i];
      end
      @(negedge b_tx_clk);
      b_tx_en = 1'b0; b_txd = 4'h0;
   endtask

   // R4/R5/R7: time crs on side A around an A-only frame
   task automatic time_crs_a;
      int e;
      wait (a_tx_en === 1'b1);
      e = 0;
      do begin
         @(posedge ref_clk); e++;
         @(negedge ref_clk);
         if (e <= 3) chk(a_crs === 1'b0, "R4", "crs too early", e, 4);
      end while (a_crs !== 1'b1 && e < 40);
      chk(e >= 4 && e <= NREF + 3, "R4", "crs rise edge", e, 4);
      if (n_delays < 16) begin delays[n_delays] = e; n_delays++; end
      wait (a_tx_en === 1'b0);
      e = 0;
      do begin
         @(posedge ref_clk); e++;
         @(negedge ref_clk);
      end while (a_crs !== 1'b0 && e < 40);
      chk(e <= 2, "R5", "crs fall edge", e, 2);
   endtask

   task automatic drain;
      repeat (40) @(negedge b_rx_clk);
      repeat (10) @(negedge a_rx_clk);
   endtask

   // ---------------- main sequence ----------------
   initial begin
      void'($urandom(32'd7151));
      repeat (5) @(negedge ref_clk);
      chk({a_rx_dv, a_rx_er, a_crs, a_col, b_rx_dv, b_rx_er, b_crs, b_col} === 8'h00,
          "R1", "outputs in reset", 0, 0);
      rst_n = 1'b1;
      repeat (20) @(negedge ref_clk);
      chk({a_rx_dv, a_rx_er, a_crs, a_col, b_rx_dv, b_rx_er, b_crs, b_col} === 8'h00 &&
          a_rxd === 4'h0 && b_rxd === 4'h0, "R1", "idle outputs", 0, 0);

      // R2 + R4/R5/R7 + R6 (no collision one-sided)
      col_a_seen = 1'b0; col_b_seen = 1'b0;
      for (int f = 0; f < 6; f++) begin
         fill_frames(48);
         b_n = 0;
         fork
            send_a(48, 1'b0);
            time_crs_a();
         join
         drain();
         chk(b_n == 48, "R2", "A->B nibble count", b_n, 48);
         chk(b_mismatches(48) == 0, "R2", "A->B mismatches", b_mismatches(48), 0);
      end
      chk(!col_a_seen && !col_b_seen, "R6", "col in one-sided traffic",
          int'(col_a_seen) + int'(col_b_seen), 0);
      begin
         bit varied = 1'b0;
         for (int i = 1; i < n_delays; i++) if (delays[i] != delays[0]) varied = 1'b1;
         chk(varied, "R7", "distinct crs delays", int'(varied), 1);
      end

      // R3: B -> A
      for (int f = 0; f < 3; f++) begin
         fill_frames(40);
         a_n = 0;
         send_b(40);
         drain();
         chk(a_n == 40, "R3", "B->A nibble count", a_n, 40);
         chk(a_mismatches(40) == 0, "R3", "B->A mismatches", a_mismatches(40), 0);
      end

      // R6: both sides at once
      fill_frames(40);
      a_n = 0; b_n = 0; col_a_seen = 1'b0; col_b_seen = 1'b0;
      fork
         send_a(40, 1'b0);
         send_b(40);
      join
      drain();
      chk(col_a_seen, "R6", "col on side A", int'(col_a_seen), 1);
      chk(col_b_seen, "R6", "col on side B", int'(col_b_seen), 1);
      repeat (5) @(negedge ref_clk);
      chk(a_col === 1'b0 && b_col === 1'b0 && a_crs === 1'b0 && b_crs === 1'b0,
          "R6", "col/crs idle after", int'(a_col) + int'(b_col), 0);
      chk(a_mismatches(40) == 0 && b_mismatches(40) == 0, "R6", "data under collision",
          a_mismatches(40) + b_mismatches(40), 0);

      // R9: tx_er held high changes nothing
      fill_frames(48);
      b_n = 0;
      send_a(48, 1'b1);
      drain();
      chk(b_n == 48 && b_mismatches(48) == 0, "R9", "frame with tx_er", b_mismatches(48), 0);

      // R10: overflow with a slow receive clock
      b_rx_half = 120.0;
      repeat (10) @(negedge b_rx_clk);
      fill_frames(64);
      b_n = 0;
      send_a(64, 1'b0);
      repeat (100) @(negedge b_rx_clk);
      chk(b_n < 64 && b_n >= DEPTH, "R10", "nibbles kept on overflow", b_n, DEPTH);
      chk(b_is_subseq(64), "R10", "received is in-order subsequence", int'(b_is_subseq(64)), 1);
      chk(b_buf[0] === a_frm[0], "R10", "first nibble", int'(b_buf[0]), int'(a_frm[0]));
      b_rx_half = 40.0;
      repeat (20) @(negedge b_rx_clk);

      // R11: underrun with a slow transmit clock
      a_tx_half = 60.0;
      repeat (10) @(negedge a_tx_clk);
      fill_frames(32);
      b_n = 0; b_rises = 0;
      send_a(32, 1'b0);
      drain();
      chk(b_rises > 1, "R11", "rx_dv gaps in frame", b_rises, 2);
      chk(b_n == 32 && b_mismatches(32) == 0, "R11", "no loss on underrun", b_n, 32);
      a_tx_half = 40.0;
      repeat (10) @(negedge a_tx_clk);

      // R8: error injection statistics
      chk(er_viol == 0, "R8", "rx_er without rx_dv", er_viol, 0);
      chk(er_cnt >= 1, "R8", "rx_er seen", er_cnt, 1);
      chk(er_cnt * 256 <= nib_cnt * THRESH * 4, "R8", "rx_er rate bound", er_cnt,
          (nib_cnt * THRESH * 4) / 256);

      report();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge ref_clk);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

endmodule